// File: doc/BRIEF.md
# Counter Clock and Gate Source Selector

This block sits in front of a bank of counter groups, each holding three 16-bit counter channels, and picks for every channel the signal that clocks it and the signal that gates it. Software writes a 5-bit clock code and a 5-bit gate code per channel through a small write port and can read either code back through a combinational read port. From these codes the block steers one of many candidates onto each channel's clock line and gate line. Clock candidates are the channel's own clock pin, six internal rate strobes, the preceding channel's output, a clock input shared by the group, fixed levels and a pattern-detect flag. Gate candidates are fixed levels, the channel's own gate pin (true or inverted), the output of the channel two places back (true or inverted) and three pattern signals, with their inverted forms. The counters and the pattern comparator are outside the block.

All channels of all groups form one ring. The channel feeding a channel's clock tap is the one just before it, and the channel feeding its gate tap is the one two places before it. Across a group boundary both taps reach into the previous group, and the first group wraps round to the last. Each channel keeps its own pattern tracker, a three-state machine with these states. PT_WAIT means the pattern has not yet been seen. PT_SEEN means the pattern has been seen and is still present. PT_GONE means the pattern has been seen and has since dropped. The tracker moves from PT_WAIT to PT_SEEN when the pattern flag is sampled high. It moves from PT_SEEN to PT_GONE when the flag is sampled low. It stays in PT_GONE. A write of that channel's gate code returns it to PT_WAIT from any state, and this takes priority over the other moves. The tracker produces the "occurred" latch (high outside PT_WAIT) and the "gone-away" latch (low only in PT_GONE).

Each channel's clock and gate pins are bidirectional at board level. The block drives their output enables, so a pin is an input only while it is the selected source. Internal rates are one-cycle strobes divided down from the system clock, which is taken to run at 20 MHz.

Top module: `ctr_src_select`

## Requirements
- R1: After reset every clock code reads 0 and every gate code reads 2, so all clock-pin and gate-pin output enables are low.
- R2: A write with wr_en high stores wr_data into the clock code (wr_gate=0) or gate code (wr_gate=1) of channel wr_chan, visible on the read port and outputs after the next clock edge. A write to a channel number at or above the channel count changes nothing, and reading such a channel returns 0.
- R3: Clock code 0 passes the channel's own clock pin, 7 the clock input of its group (channel i belongs to group i/3), 8 a constant 1, 9 a constant 0 and 10 the pattern-present flag.
- R4: Clock codes 11, 1, 2, 3, 4 and 5 give one-cycle strobes every 1, 2, 20, 200, 2000 and 20000 system clocks respectively. Each slower strobe coincides with a strobe of the next faster one.
- R5: Clock code 6 passes the output of channel (i-1) mod N, where N is the total channel count, so channel 0 of a group is clocked from channel 2 of the previous group and group 0 wraps to the last group.
- R6: Gate code 0 gives 1, code 1 gives 0, code 2 passes the channel's own gate pin and code 6 its inverse.
- R7: Gate code 7 passes the output of channel (i-2) mod N and code 3 its inverse.
- R8: Gate code 8 passes the pattern-present flag and code 11 its inverse.
- R9: Gate code 9 is low until the pattern flag is sampled high at a clock edge, then high from that edge on until cleared. Code 12 is its inverse.
- R10: Gate code 10 is high until the pattern flag, having been seen, is sampled low. It is then low until cleared, even if the pattern returns. Code 13 is its inverse.
- R11: Writing a channel's gate code (any value) returns its two latches to occurred=0 and gone-away=1 at that edge, overriding the pattern flag. Other channels' latches are unaffected.
- R12: Clock codes 12 to 31 and gate codes 4, 5 and 14 to 31 give a constant 0.
- R13: clk_pin_oe of a channel is high exactly when its clock code is not 0, and gat_pin_oe exactly when its gate code is not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one select code |
| wr_gate | input | 1 | 1 selects the gate code, 0 the clock code |
| wr_chan | input | CHW | Channel number for the write |
| wr_data | input | 5 | Code value to store |
| rd_chan | input | CHW | Channel number for readback |
| rd_gate | input | 1 | 1 reads the gate code, 0 the clock code |
| rd_data | output | 5 | Code read back (0 for channels out of range) |
| clk_pin_in | input | NTOT | Per-channel clock pin input value |
| gat_pin_in | input | NTOT | Per-channel gate pin input value |
| grp_clk_in | input | NGRP | Clock input shared within each group |
| ctr_out | input | NTOT | Output of each counter channel |
| pattern_present | input | 1 | Pattern-detect flag from the comparator |
| chan_clk | output | NTOT | Selected clock for each channel |
| chan_gate | output | NTOT | Selected gate for each channel |
| clk_pin_oe | output | NTOT | Output enable for each clock pin |
| gat_pin_oe | output | NTOT | Output enable for each gate pin |

## Verification
The hardest situation to reach is a gone-away latch that has dropped low while the pattern flag has come back high. A second case is a latch clear that coincides with the pattern still being present, so the tracker must leave PT_WAIT again on the following edge. Directed sequences walk the pattern flag high, low, high again, and then rewrite the gate code while the flag is still high, checking each step. The ring taps across the group boundary and the slowest rate strobes are also hard to reach by chance. Directed writes put channel 0 on the previous-channel clock and measure the gap between strobes for every rate code. A seeded random phase then mixes writes (including ones to absent channels) with random pin, counter and pattern activity against a bench model of all codes and latches.

// File: rtl/ctr_src_pkg.sv
package ctr_src_pkg;

    localparam int SEL_W      = 5;
    localparam int CH_PER_GRP = 3;
    localparam int N_RATE     = 6;

    // clock select codes (values are the software encoding)
    localparam logic [SEL_W-1:0] CK_PIN   = 5'd0;
    localparam logic [SEL_W-1:0] CK_R10M  = 5'd1;
    localparam logic [SEL_W-1:0] CK_R1M   = 5'd2;
    localparam logic [SEL_W-1:0] CK_R100K = 5'd3;
    localparam logic [SEL_W-1:0] CK_R10K  = 5'd4;
    localparam logic [SEL_W-1:0] CK_R1K   = 5'd5;
    localparam logic [SEL_W-1:0] CK_PREV  = 5'd6;
    localparam logic [SEL_W-1:0] CK_GRP   = 5'd7;
    localparam logic [SEL_W-1:0] CK_HIGH  = 5'd8;
    localparam logic [SEL_W-1:0] CK_LOW   = 5'd9;
    localparam logic [SEL_W-1:0] CK_PAT   = 5'd10;
    localparam logic [SEL_W-1:0] CK_R20M  = 5'd11;

    // gate select codes
    localparam logic [SEL_W-1:0] GT_ON     = 5'd0;
    localparam logic [SEL_W-1:0] GT_OFF    = 5'd1;
    localparam logic [SEL_W-1:0] GT_PIN    = 5'd2;
    localparam logic [SEL_W-1:0] GT_FAR_N  = 5'd3;
    localparam logic [SEL_W-1:0] GT_PIN_N  = 5'd6;
    localparam logic [SEL_W-1:0] GT_FAR    = 5'd7;
    localparam logic [SEL_W-1:0] GT_PAT    = 5'd8;
    localparam logic [SEL_W-1:0] GT_OCC    = 5'd9;
    localparam logic [SEL_W-1:0] GT_STAY   = 5'd10;
    localparam logic [SEL_W-1:0] GT_PAT_N  = 5'd11;
    localparam logic [SEL_W-1:0] GT_OCC_N  = 5'd12;
    localparam logic [SEL_W-1:0] GT_STAY_N = 5'd13;

    typedef enum logic [1:0] {
        PT_WAIT = 2'd0,
        PT_SEEN = 2'd1,
        PT_GONE = 2'd2
    } pat_state_t;

endpackage

// File: rtl/ctr_rate_gen.sv
module ctr_rate_gen #(
    parameter int N_RATE     = 6,
    parameter int FIRST_DIV  = 2,
    parameter int DECADE_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_RATE-1:0] tick
);
    localparam int MAX_DIV = (FIRST_DIV > DECADE_DIV) ? FIRST_DIV : DECADE_DIV;
    localparam int CW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    logic [N_RATE-1:0][CW-1:0] cnt_q;

    function automatic logic [CW-1:0] stage_last(input int k);
        return (k == 1) ? CW'(FIRST_DIV - 1) : CW'(DECADE_DIV - 1);
    endfunction

    always_comb begin
        tick[0] = 1'b1;
        for (int k = 1; k < N_RATE; k++) begin
            tick[k] = tick[k-1] && (cnt_q[k] == stage_last(k));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q[0] <= '0;
            for (int k = 1; k < N_RATE; k++) begin
                if (tick[k-1]) begin
                    cnt_q[k] <= (cnt_q[k] == stage_last(k)) ? '0 : cnt_q[k] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ctr_pat_track.sv
module ctr_pat_track
    import ctr_src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pattern,
    output logic occ_o,
    output logic stay_o
);
    pat_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PT_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = PT_WAIT;
        end else begin
            unique case (state_q)
                PT_WAIT: if (pattern)  state_d = PT_SEEN;
                PT_SEEN: if (!pattern) state_d = PT_GONE;
                PT_GONE: state_d = PT_GONE;
                default: state_d = PT_WAIT;
            endcase
        end
    end

    always_comb begin
        occ_o  = (state_q != PT_WAIT);
        stay_o = (state_q != PT_GONE);
    end
endmodule

// File: rtl/ctr_src_mux.sv
module ctr_src_mux
    import ctr_src_pkg::*;
(
    input  logic [SEL_W-1:0]  clk_code,
    input  logic [SEL_W-1:0]  gate_code,
    input  logic              own_clk_pin,
    input  logic              own_gat_pin,
    input  logic              grp_clk,
    input  logic              prev_out,
    input  logic              far_out,
    input  logic              pattern,
    input  logic              occ,
    input  logic              stay,
    input  logic [N_RATE-1:0] rate_tick,
    output logic              sel_clk,
    output logic              sel_gate,
    output logic              clk_oe,
    output logic              gat_oe
);
    always_comb begin
        unique case (clk_code)
            CK_PIN:   sel_clk = own_clk_pin;
            CK_R10M:  sel_clk = rate_tick[1];
            CK_R1M:   sel_clk = rate_tick[2];
            CK_R100K: sel_clk = rate_tick[3];
            CK_R10K:  sel_clk = rate_tick[4];
            CK_R1K:   sel_clk = rate_tick[5];
            CK_PREV:  sel_clk = prev_out;
            CK_GRP:   sel_clk = grp_clk;
            CK_HIGH:  sel_clk = 1'b1;
            CK_LOW:   sel_clk = 1'b0;
            CK_PAT:   sel_clk = pattern;
            CK_R20M:  sel_clk = rate_tick[0];
            default:  sel_clk = 1'b0;
        endcase
    end

    always_comb begin
        unique case (gate_code)
            GT_ON:     sel_gate = 1'b1;
            GT_OFF:    sel_gate = 1'b0;
            GT_PIN:    sel_gate = own_gat_pin;
            GT_FAR_N:  sel_gate = ~far_out;
            GT_PIN_N:  sel_gate = ~own_gat_pin;
            GT_FAR:    sel_gate = far_out;
            GT_PAT:    sel_gate = pattern;
            GT_OCC:    sel_gate = occ;
            GT_STAY:   sel_gate = stay;
            GT_PAT_N:  sel_gate = ~pattern;
            GT_OCC_N:  sel_gate = ~occ;
            GT_STAY_N: sel_gate = ~stay;
            default:   sel_gate = 1'b0;
        endcase
    end

    always_comb begin
        clk_oe = (clk_code != CK_PIN);
        gat_oe = (gate_code != GT_PIN);
    end
endmodule

// File: rtl/ctr_src_select.sv
module ctr_src_select
    import ctr_src_pkg::*;
#(
    parameter int NGRP = 2,
    parameter int NTOT = NGRP * CH_PER_GRP,
    parameter int CHW  = $clog2(NTOT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_gate,
    input  logic [CHW-1:0]   wr_chan,
    input  logic [SEL_W-1:0] wr_data,
    input  logic [CHW-1:0]   rd_chan,
    input  logic             rd_gate,
    output logic [SEL_W-1:0] rd_data,
    input  logic [NTOT-1:0]  clk_pin_in,
    input  logic [NTOT-1:0]  gat_pin_in,
    input  logic [NGRP-1:0]  grp_clk_in,
    input  logic [NTOT-1:0]  ctr_out,
    input  logic             pattern_present,
    output logic [NTOT-1:0]  chan_clk,
    output logic [NTOT-1:0]  chan_gate,
    output logic [NTOT-1:0]  clk_pin_oe,
    output logic [NTOT-1:0]  gat_pin_oe
);
    logic [NTOT-1:0][SEL_W-1:0] clk_sel_q;
    logic [NTOT-1:0][SEL_W-1:0] gate_sel_q;
    logic [N_RATE-1:0]          rate_tick;
    logic [NTOT-1:0]            occ_v;
    logic [NTOT-1:0]            stay_v;
    logic [NTOT-1:0]            gate_wr_hit;

    ctr_rate_gen #(.N_RATE(N_RATE)) u_rates (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rate_tick)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NTOT; i++) begin
            if (rd_chan == CHW'(i)) rd_data = rd_gate ? gate_sel_q[i] : clk_sel_q[i];
        end
    end

    for (genvar i = 0; i < NTOT; i++) begin : g_chan
        localparam int PREV = (i + NTOT - 1) % NTOT;
        localparam int FAR  = (i + 2 * NTOT - 2) % NTOT;
        localparam int GRP  = i / CH_PER_GRP;

        assign gate_wr_hit[i] = wr_en && wr_gate && (wr_chan == CHW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                clk_sel_q[i]  <= CK_PIN;
                gate_sel_q[i] <= GT_PIN;
            end else if (wr_en && (wr_chan == CHW'(i))) begin
                if (wr_gate) gate_sel_q[i] <= wr_data;
                else         clk_sel_q[i]  <= wr_data;
            end
        end

        ctr_pat_track u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (gate_wr_hit[i]),
            .pattern (pattern_present),
            .occ_o   (occ_v[i]),
            .stay_o  (stay_v[i])
        );

        ctr_src_mux u_mux (
            .clk_code    (clk_sel_q[i]),
            .gate_code   (gate_sel_q[i]),
            .own_clk_pin (clk_pin_in[i]),
            .own_gat_pin (gat_pin_in[i]),
            .grp_clk     (grp_clk_in[GRP]),
            .prev_out    (ctr_out[PREV]),
            .far_out     (ctr_out[FAR]),
            .pattern     (pattern_present),
            .occ         (occ_v[i]),
            .stay        (stay_v[i]),
            .rate_tick   (rate_tick),
            .sel_clk     (chan_clk[i]),
            .sel_gate    (chan_gate[i]),
            .clk_oe      (clk_pin_oe[i]),
            .gat_oe      (gat_pin_oe[i])
        );
    end
endmodule

// File: rtl/ctr_src_checker.sv
module ctr_src_checker
    import ctr_src_pkg::*;
#(
    parameter int NTOT = 6,
    parameter int CHW  = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       wr_gate,
    input logic [CHW-1:0]             wr_chan,
    input logic [SEL_W-1:0]           wr_data,
    input logic [NTOT-1:0][SEL_W-1:0] clk_sel_q,
    input logic [NTOT-1:0][SEL_W-1:0] gate_sel_q,
    input logic [NTOT-1:0]            ctr_out,
    input logic [NTOT-1:0]            chan_clk,
    input logic [NTOT-1:0]            chan_gate,
    input logic [NTOT-1:0]            clk_pin_oe,
    input logic [NTOT-1:0]            gat_pin_oe,
    input logic [N_RATE-1:0]          rate_tick,
    input logic [NTOT-1:0]            occ_v,
    input logic [NTOT-1:0]            stay_v
);
    for (genvar k = 1; k < N_RATE; k++) begin : g_rate
        AST_RATE_NEST: assert property (@(posedge clk) disable iff (!rst_n)
            rate_tick[k] |-> rate_tick[k-1]); // R4
    end

    for (genvar i = 0; i < NTOT; i++) begin : g_chk
        localparam int PREV = (i + NTOT - 1) % NTOT;
        localparam int FAR  = (i + 2 * NTOT - 2) % NTOT;

        AST_CLK_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_gate && wr_chan == CHW'(i) && wr_data == CK_PIN) |=> !clk_pin_oe[i]); // R13
        AST_GATE_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_gate && wr_chan == CHW'(i) && wr_data != GT_PIN) |=> gat_pin_oe[i]); // R13
        AST_RING_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_sel_q[i] == CK_PREV) |-> (chan_clk[i] == ctr_out[PREV])); // R5
        AST_RING_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_sel_q[i] == GT_FAR) |-> (chan_gate[i] == ctr_out[FAR])); // R7
        AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_gate && wr_chan == CHW'(i)) |=> (!occ_v[i] && stay_v[i])); // R11
        AST_GONE_AFTER_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
            !stay_v[i] |-> occ_v[i]); // R10
        AST_OCC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (occ_v[i] && !(wr_en && wr_gate && wr_chan == CHW'(i))) |=> occ_v[i]); // R9
    end
endmodule

bind ctr_src_select ctr_src_checker #(.NTOT(NTOT), .CHW(CHW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_gate    (wr_gate),
    .wr_chan    (wr_chan),
    .wr_data    (wr_data),
    .clk_sel_q  (clk_sel_q),
    .gate_sel_q (gate_sel_q),
    .ctr_out    (ctr_out),
    .chan_clk   (chan_clk),
    .chan_gate  (chan_gate),
    .clk_pin_oe (clk_pin_oe),
    .gat_pin_oe (gat_pin_oe),
    .rate_tick  (rate_tick),
    .occ_v      (occ_v),
    .stay_v     (stay_v)
);

// File: tb/sim_ctr_src_select.sv
`timescale 1ns/10ps
module sim_ctr_src_select;
    localparam int NGRP = 2;
    localparam int NTOT = NGRP * 3;
    localparam int CHW  = $clog2(NTOT + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0, wr_gate = 1'b0, rd_gate = 1'b0;
    logic [CHW-1:0]  wr_chan = '0, rd_chan = '0;
    logic [4:0]      wr_data = '0;
    logic [4:0]      rd_data;
    logic [NTOT-1:0] clk_pin_in = '0, gat_pin_in = '0, ctr_out = '0;
    logic [NGRP-1:0] grp_clk_in = '0;
    logic            pattern_present = 1'b0;
    logic [NTOT-1:0] chan_clk, chan_gate, clk_pin_oe, gat_pin_oe;

    int n_vec = 0, n_bad = 0;
    logic [4:0] clk_m [NTOT];
    logic [4:0] gate_m[NTOT];
    logic       occ_m [NTOT];
    logic       stay_m[NTOT];

    always #4 clk = ~clk;

    ctr_src_select #(.NGRP(NGRP)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_gate(wr_gate), .wr_chan(wr_chan),
        .wr_data(wr_data), .rd_chan(rd_chan), .rd_gate(rd_gate), .rd_data(rd_data),
        .clk_pin_in(clk_pin_in), .gat_pin_in(gat_pin_in), .grp_clk_in(grp_clk_in),
        .ctr_out(ctr_out), .pattern_present(pattern_present), .chan_clk(chan_clk),
        .chan_gate(chan_gate), .clk_pin_oe(clk_pin_oe), .gat_pin_oe(gat_pin_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_rate(input logic [4:0] c);
        return (c >= 5'd1 && c <= 5'd5) || c == 5'd11;
    endfunction

    function automatic logic exp_clk(input int i);
        case (clk_m[i])
            5'd0:    return clk_pin_in[i];
            5'd6:    return ctr_out[(i + NTOT - 1) % NTOT];
            5'd7:    return grp_clk_in[i / 3];
            5'd8:    return 1'b1;
            5'd10:   return pattern_present;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_gate(input int i);
        case (gate_m[i])
            5'd0:    return 1'b1;
            5'd2:    return gat_pin_in[i];
            5'd3:    return ~ctr_out[(i + NTOT - 2) % NTOT];
            5'd6:    return ~gat_pin_in[i];
            5'd7:    return ctr_out[(i + NTOT - 2) % NTOT];
            5'd8:    return pattern_present;
            5'd9:    return occ_m[i];
            5'd10:   return stay_m[i];
            5'd11:   return ~pattern_present;
            5'd12:   return ~occ_m[i];
            5'd13:   return ~stay_m[i];
            default: return 1'b0;
        endcase
    endfunction

    // bench model of codes and latches, advanced at each rising edge
    task automatic step();
        @(posedge clk);
        for (int i = 0; i < NTOT; i++) begin
            if (wr_en && wr_gate && int'(wr_chan) == i) begin
                occ_m[i] = 1'b0; stay_m[i] = 1'b1;
            end else if (!occ_m[i] && pattern_present) begin
                occ_m[i] = 1'b1;
            end else if (occ_m[i] && !pattern_present) begin
                stay_m[i] = 1'b0;
            end
        end
        if (wr_en && int'(wr_chan) < NTOT) begin
            if (wr_gate) gate_m[wr_chan] = wr_data;
            else         clk_m[wr_chan]  = wr_data;
        end
        @(negedge clk);
    endtask

    task automatic do_write(input int ch, input bit g, input int d);
        wr_en = 1'b1; wr_gate = g; wr_chan = CHW'(ch); wr_data = 5'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NTOT; i++) begin
            if (!is_rate(clk_m[i])) chk({tag, " clk"}, int'(chan_clk[i]), int'(exp_clk(i)));
            chk({tag, " gate"}, int'(chan_gate[i]), int'(exp_gate(i)));
            chk("R13 clk oe", int'(clk_pin_oe[i]), int'(clk_m[i] != 5'd0));
            chk("R13 gate oe", int'(gat_pin_oe[i]), int'(gate_m[i] != 5'd2));
        end
    endtask

    task automatic measure(input int code, input int gap_exp, input string tag);
        int gap;
        bit seen;
        int lim;
        lim = gap_exp * 2 + 4;
        do_write(3, 1'b0, code);
        seen = 1'b0;
        for (int n = 0; n < lim && !seen; n++) begin
            if (chan_clk[3]) seen = 1'b1;
            else step();
        end
        chk({tag, " strobe seen"}, int'(seen), 1);
        step();
        gap = 1;
        if (gap_exp > 1) chk({tag, " single cycle"}, int'(chan_clk[3]), 0);
        while (!chan_clk[3] && gap < lim) begin
            step();
            gap++;
        end
        chk({tag, " spacing"}, gap, gap_exp);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all) act=timeout exp=finished");
        summary();
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd1357);
        for (int i = 0; i < NTOT; i++) begin
            clk_m[i] = 5'd0; gate_m[i] = 5'd2; occ_m[i] = 1'b0; stay_m[i] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < NTOT; i++) begin
            rd_chan = CHW'(i); rd_gate = 1'b0; #0.2;
            chk("R1 clk code", int'(rd_data), 0);
            rd_gate = 1'b1; #0.2;
            chk("R1 gate code", int'(rd_data), 2);
        end
        chk("R1 clk oe", int'(clk_pin_oe), 0);
        chk("R1 gate oe", int'(gat_pin_oe), 0);

        // R2 out-of-range write ignored, reads 0
        do_write(NTOT, 1'b0, 5'd9);
        do_write(NTOT, 1'b1, 5'd9);
        rd_chan = CHW'(NTOT); rd_gate = 1'b0; #0.2;
        chk("R2 absent chan read", int'(rd_data), 0);
        for (int i = 0; i < NTOT; i++) begin
            rd_chan = CHW'(i); rd_gate = 1'b0; #0.2;
            chk("R2 untouched clk", int'(rd_data), 0);
        end
        do_write(4, 1'b1, 5'd13);
        rd_chan = CHW'(4); rd_gate = 1'b1; #0.2;
        chk("R2 readback", int'(rd_data), 13);

        // R5 ring wrap: channel 0 clocked from channel NTOT-1, channel 3 from 2
        do_write(0, 1'b0, 6);
        do_write(3, 1'b0, 6);
        ctr_out = NTOT'(1) << (NTOT - 1); #0.2;
        chk("R5 wrap to last group", int'(chan_clk[0]), 1);
        chk("R5 no cross to ch3", int'(chan_clk[3]), 0);
        ctr_out = NTOT'(1) << 2; #0.2;
        chk("R5 group boundary", int'(chan_clk[3]), 1);
        chk("R5 ch0 low", int'(chan_clk[0]), 0);

        // R7 far tap: channel 1 gate from channel NTOT-1, channel 2 from 0
        do_write(1, 1'b1, 7);
        do_write(2, 1'b1, 3);
        ctr_out = NTOT'(1) << (NTOT - 1); #0.2;
        chk("R7 ch1 true far", int'(chan_gate[1]), 1);
        chk("R7 ch2 inverted far", int'(chan_gate[2]), 1);
        ctr_out = NTOT'(1); #0.2;
        chk("R7 ch1 true far low", int'(chan_gate[1]), 0);
        chk("R7 ch2 inverted far low", int'(chan_gate[2]), 0);
        ctr_out = '0;

        // R4 rate strobes
        measure(11, 1, "R4 code11");
        measure(1, 2, "R4 code1");
        measure(2, 20, "R4 code2");
        measure(3, 200, "R4 code3");
        measure(4, 2000, "R4 code4");
        measure(5, 20000, "R4 code5");

        // R9 R10 R11 pattern latches
        pattern_present = 1'b0;
        do_write(1, 1'b1, 9);
        do_write(2, 1'b1, 10);
        chk("R9 occ idle", int'(chan_gate[1]), 0);
        chk("R10 stay idle", int'(chan_gate[2]), 1);
        pattern_present = 1'b1;
        #0.2;
        chk("R9 occ before edge", int'(chan_gate[1]), 0);
        step();
        chk("R9 occ set", int'(chan_gate[1]), 1);
        chk("R10 stay while present", int'(chan_gate[2]), 1);
        pattern_present = 1'b0;
        step();
        chk("R9 occ sticky", int'(chan_gate[1]), 1);
        chk("R10 gone", int'(chan_gate[2]), 0);
        pattern_present = 1'b1;
        step();
        chk("R10 stays low on return", int'(chan_gate[2]), 0);
        do_write(2, 1'b1, 13);
        chk("R11 cleared inverted stay", int'(chan_gate[2]), 0);
        chk("R11 other channel kept", int'(chan_gate[1]), 1);
        step();
        chk("R10 rearmed inverted", int'(chan_gate[2]), 0);
        pattern_present = 1'b0;
        step();
        chk("R10 inverted gone", int'(chan_gate[2]), 1);
        do_write(1, 1'b1, 12);
        chk("R11 R9 inverted cleared", int'(chan_gate[1]), 1);

        // R3 R6 R8 R12 directed fixed codes on channel 5
        do_write(5, 1'b0, 8);
        chk("R3 high", int'(chan_clk[5]), 1);
        do_write(5, 1'b0, 9);
        chk("R3 low", int'(chan_clk[5]), 0);
        grp_clk_in = 2'b10;
        do_write(5, 1'b0, 7);
        chk("R3 group clock", int'(chan_clk[5]), 1);
        do_write(5, 1'b0, 31);
        chk("R12 clk code 31", int'(chan_clk[5]), 0);
        do_write(5, 1'b1, 0);
        chk("R6 gate on", int'(chan_gate[5]), 1);
        do_write(5, 1'b1, 4);
        chk("R12 gate code 4", int'(chan_gate[5]), 0);
        gat_pin_in = '0;
        do_write(5, 1'b1, 6);
        chk("R6 inverted pin", int'(chan_gate[5]), 1);
        pattern_present = 1'b1;
        do_write(5, 1'b1, 11);
        chk("R8 inverted pattern", int'(chan_gate[5]), 0);
        pattern_present = 1'b0;
        step();

        // seeded random mix, R2 R3 R6 R8 R9 R10 R11 R12 R13
        for (int it = 0; it < 1500; it++) begin
            clk_pin_in = NTOT'($urandom);
            gat_pin_in = NTOT'($urandom);
            ctr_out    = NTOT'($urandom);
            grp_clk_in = NGRP'($urandom);
            if ($urandom % 4 == 0) pattern_present = ~pattern_present;
            if ($urandom % 2 == 0) begin
                wr_en = 1'b1; wr_gate = 1'($urandom);
                wr_chan = CHW'($urandom % (NTOT + 2)); wr_data = 5'($urandom);
            end
            step();
            wr_en = 1'b0;
            check_all("R3 R6 R8 R12 random");
            begin
                int c;
                c = int'($urandom % NTOT);
                rd_chan = CHW'(c); rd_gate = 1'b0; #0.2;
                chk("R2 random clk readback", int'(rd_data), int'(clk_m[c]));
                rd_gate = 1'b1; #0.2;
                chk("R2 random gate readback", int'(rd_data), int'(gate_m[c]));
            end
        end

        summary();
        $finish;
    end
endmodule